// File: doc/BRIEF.md
# Multi-Bank Clock Divider and Output Disable Controller

This block produces five output-bank clocks and one feedback-bank clock from a single fast clock, `clk_ref`. The reference waveform is represented by a phase bit that toggles on every `clk_ref` edge. A shared two-bit divide counter advances once per reference period. Each bank picks its waveform with a 5-bit mode code: pass-through, inverted, divide-by-2 or divide-by-4. Every bank drives a true output, a complement output and an output-enable. Output-enable low stands for a tri-stated pin.

Each of the five output banks has an active-high disable input. A global gate-mode bit chooses what a disabled bank does: float, or hold a fixed level picked by a stop-level bit. An active-low power-down input disables all six banks, including the feedback bank. When all five output-bank disables are set together, the divide counter is held at zero. The divided clocks therefore restart from a known phase once any bank is enabled again.

All outputs are registered on `clk_ref`. Mode, disable and power-down changes reach the pins at the next edge, so no runt pulse is produced. The block has no data stream, so every pin is a plain level-sensitive control or clock output.

Top module: `bank_clock_divider`

## Requirements
- R1: After reset the reference phase is 0 and inverts on every `clk_ref` edge. A bank with mode 5'b00000 drives its true output with the phase value sampled at the previous edge.
- R2: Mode 5'b10000 drives the true output with the inverse of that sampled phase.
- R3: The divide counter is two bits wide and starts at 0 after reset. It increments on every edge where the phase is 1. Mode 5'b10001 drives counter bit 0, which gives a period of four `clk_ref` cycles.
- R4: Mode 5'b10010 drives counter bit 1, which gives a period of eight `clk_ref` cycles.
- R5: Any mode code other than 5'b00000, 5'b10000, 5'b10001 and 5'b10010 behaves exactly like 5'b00000.
- R6: An enabled bank drives output-enable 1 and a complement output equal to the inverse of its true output, whatever the gate-mode and stop-level bits are.
- R7: A disabled bank with gate-mode 0 drives output-enable 0, and its true and complement outputs both 0.
- R8: A disabled bank with gate-mode 1 drives output-enable 1. Its true output is the inverse of stop-level and its complement output equals stop-level.
- R9: While `pwr_dn_n` is 0, all six banks, the feedback bank included (bit 5 of every packed vector), follow R7 or R8.
- R10: On an edge where all five bits of `bank_dis` are 1, the divide counter is cleared to 0. Counting resumes from 0 under R3 rules once any bit is 0.
- R11: While all five output banks are disabled, a feedback bank set to 5'b10001 or 5'b10010 holds its true output at 0 and stops toggling.
- R12: While reset is low all outputs are 0. Each output reflects the inputs sampled at the previous `clk_ref` edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast clock. The reference phase toggles on each edge. |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_mode | input | 30 | Six 5-bit mode codes. Bank b uses bits [5b+4:5b]. Bank 5 is the feedback bank. |
| bank_dis | input | 5 | Active-high disables for output banks 0 to 4 |
| gate_mode | input | 1 | 1 = a disabled bank holds a level, 0 = a disabled bank floats |
| stop_level | input | 1 | Level select for gated banks (see R8) |
| pwr_dn_n | input | 1 | Active-low power-down that disables every bank |
| q_true | output | 6 | True clock output per bank |
| q_comp | output | 6 | Complement clock output per bank |
| q_oe | output | 6 | Output-enable per bank. 0 models a tri-stated pin. |

## Verification
The bench builds the block with its default of five output banks plus the feedback bank. At that width, an all-disabled pattern comes up often enough under biased random disables to exercise the counter hold and the restart phase many times. Mode codes are drawn from the four defined codes plus arbitrary 5-bit values, so the zero-skew fallback is hit across every bank. Random gate-mode, stop-level and power-down settings reach each combination of the disable table while the divided clocks are at every counter phase.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int MODE_W = 5;
  localparam int DIV_W  = 2;

  localparam logic [MODE_W-1:0] CODE_PASS = 5'b00000;
  localparam logic [MODE_W-1:0] CODE_INV  = 5'b10000;
  localparam logic [MODE_W-1:0] CODE_DIV2 = 5'b10001;
  localparam logic [MODE_W-1:0] CODE_DIV4 = 5'b10010;

  typedef enum logic [1:0] {
    WAVE_PASS = 2'd0,
    WAVE_INV  = 2'd1,
    WAVE_DIV2 = 2'd2,
    WAVE_DIV4 = 2'd3
  } wave_sel_e;

  // Unlisted codes fall back to zero skew.
  function automatic wave_sel_e decode_mode(input logic [MODE_W-1:0] code);
    wave_sel_e sel;
    case (code)
      CODE_INV:  sel = WAVE_INV;
      CODE_DIV2: sel = WAVE_DIV2;
      CODE_DIV4: sel = WAVE_DIV4;
      default:   sel = WAVE_PASS;
    endcase
    return sel;
  endfunction
endpackage

// File: rtl/bcd_phase_gen.sv
module bcd_phase_gen
  import bcd_pkg::*;
(
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             hold,
  output logic             ref_ph,
  output logic [DIV_W-1:0] div_cnt
);
  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      ref_ph  <= 1'b0;
      div_cnt <= '0;
    end else begin
      ref_ph <= ~ref_ph;
      if (hold) begin
        div_cnt <= '0;
      end else if (ref_ph) begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcd_bank_driver.sv
module bcd_bank_driver
  import bcd_pkg::*;
(
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              dis,
  input  logic              gate_mode,
  input  logic              stop_level,
  input  logic              ref_ph,
  input  logic [DIV_W-1:0]  div_cnt,
  output logic              q_true,
  output logic              q_comp,
  output logic              q_oe
);
  wave_sel_e sel;
  logic      wave;

  always_comb begin
    sel = decode_mode(mode);
    case (sel)
      WAVE_INV:  wave = ~ref_ph;
      WAVE_DIV2: wave = div_cnt[0];
      WAVE_DIV4: wave = div_cnt[DIV_W-1];
      default:   wave = ref_ph;
    endcase
  end

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      q_oe   <= 1'b0;
      q_true <= 1'b0;
      q_comp <= 1'b0;
    end else if (dis) begin
      if (gate_mode) begin
        q_oe   <= 1'b1;
        q_true <= ~stop_level;
        q_comp <= stop_level;
      end else begin
        q_oe   <= 1'b0;
        q_true <= 1'b0;
        q_comp <= 1'b0;
      end
    end else begin
      q_oe   <= 1'b1;
      q_true <= wave;
      q_comp <= ~wave;
    end
  end
endmodule

// File: rtl/bank_clock_divider.sv
module bank_clock_divider
  import bcd_pkg::*;
#(
  parameter int NUM_OUT = 5
) (
  input  logic                             clk_ref,
  input  logic                             rst_n,
  input  logic [(NUM_OUT+1)*MODE_W-1:0]    bank_mode,
  input  logic [NUM_OUT-1:0]               bank_dis,
  input  logic                             gate_mode,
  input  logic                             stop_level,
  input  logic                             pwr_dn_n,
  output logic [NUM_OUT:0]                 q_true,
  output logic [NUM_OUT:0]                 q_comp,
  output logic [NUM_OUT:0]                 q_oe
);
  localparam int NB = NUM_OUT + 1;

  logic             ref_ph;
  logic [DIV_W-1:0] div_cnt;
  logic             all_off;
  logic [NB-1:0]    eff_dis;

  assign all_off = &bank_dis;

  bcd_phase_gen u_phase (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .hold    (all_off),
    .ref_ph  (ref_ph),
    .div_cnt (div_cnt)
  );

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      if (b < NUM_OUT) begin : g_out
        assign eff_dis[b] = bank_dis[b] | ~pwr_dn_n;
      end else begin : g_fb
        assign eff_dis[b] = ~pwr_dn_n;
      end

      bcd_bank_driver u_drv (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .mode       (bank_mode[b*MODE_W +: MODE_W]),
        .dis        (eff_dis[b]),
        .gate_mode  (gate_mode),
        .stop_level (stop_level),
        .ref_ph     (ref_ph),
        .div_cnt    (div_cnt),
        .q_true     (q_true[b]),
        .q_comp     (q_comp[b]),
        .q_oe       (q_oe[b])
      );
    end
  endgenerate
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker
  import bcd_pkg::*;
#(
  parameter int NUM_OUT = 5
) (
  input logic               clk_ref,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] bank_dis,
  input logic               gate_mode,
  input logic               stop_level,
  input logic               pwr_dn_n,
  input logic [NUM_OUT:0]   q_true,
  input logic [NUM_OUT:0]   q_comp,
  input logic [NUM_OUT:0]   q_oe,
  input logic               ref_ph,
  input logic [DIV_W-1:0]   div_cnt
);
  localparam int NB = NUM_OUT + 1;

  logic          past_ok;
  logic [NB-1:0] off_now;

  always_ff @(posedge clk_ref) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_chk
      if (b < NUM_OUT) begin : g_o
        assign off_now[b] = bank_dis[b] | ~pwr_dn_n;
      end else begin : g_f
        assign off_now[b] = ~pwr_dn_n;
      end

      assert_enabled_pair_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (past_ok && !$past(off_now[b])) |-> (q_oe[b] && (q_comp[b] == !q_true[b])));

      assert_float_quiet_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (past_ok && $past(off_now[b] && !gate_mode)) |-> (!q_oe[b] && !q_true[b] && !q_comp[b]));

      assert_gated_level_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (past_ok && $past(off_now[b] && gate_mode)) |->
          (q_oe[b] && (q_true[b] == !$past(stop_level)) && (q_comp[b] == $past(stop_level))));

      assert_powerdown_all_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (past_ok && $past(!pwr_dn_n && !gate_mode)) |-> !q_oe[b]);
    end
  endgenerate

  assert_phase_toggles_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    past_ok |-> (ref_ph != $past(ref_ph)));

  assert_counter_held_R10: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (past_ok && $past(&bank_dis)) |-> (div_cnt == '0));

  assert_counter_step_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (past_ok && !$past(&bank_dis) && !$past(ref_ph)) |-> $stable(div_cnt));
endmodule

bind bank_clock_divider bcd_checker #(.NUM_OUT(NUM_OUT)) u_bcd_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .bank_dis   (bank_dis),
  .gate_mode  (gate_mode),
  .stop_level (stop_level),
  .pwr_dn_n   (pwr_dn_n),
  .q_true     (q_true),
  .q_comp     (q_comp),
  .q_oe       (q_oe),
  .ref_ph     (ref_ph),
  .div_cnt    (div_cnt)
);

// File: tb/sim_bank_clock_divider.sv
`timescale 1ns/1ps
module sim_bank_clock_divider;
  localparam int NOUT = 5;
  localparam int NB   = NOUT + 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [4:0]     mode_a [NB];
  logic [NB*5-1:0] bank_mode;
  logic [NOUT-1:0] dis;
  logic           gate, stop, pd_n;
  logic [NB-1:0]  q_true, q_comp, q_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit check_on = 0;
  int tag_override = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int b = 0; b < NB; b++) bank_mode[b*5 +: 5] = mode_a[b];
  end

  bank_clock_divider #(.NUM_OUT(NOUT)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .bank_mode(bank_mode), .bank_dis(dis),
    .gate_mode(gate), .stop_level(stop), .pwr_dn_n(pd_n),
    .q_true(q_true), .q_comp(q_comp), .q_oe(q_oe));

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  function automatic logic exp_wave(logic [4:0] m, logic ph, logic [1:0] cnt);
    if (m == 5'b10000) return ~ph;
    if (m == 5'b10001) return cnt[0];
    if (m == 5'b10010) return cnt[1];
    return ph;
  endfunction

  function automatic int mode_tag(logic [4:0] m);
    if (m == 5'b00000) return 1;
    if (m == 5'b10000) return 2;
    if (m == 5'b10001) return 3;
    if (m == 5'b10010) return 4;
    return 5;
  endfunction

  // Reference model of the requirements, updated on the same edge as the design.
  logic       m_ph;
  logic [1:0] m_cnt;
  logic [NB-1:0] e_true, e_comp, e_oe;
  int e_tag [NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 1'b0; m_cnt <= 2'd0;
      e_true <= '0; e_comp <= '0; e_oe <= '0;
      for (int b = 0; b < NB; b++) e_tag[b] <= 12;
    end else begin
      m_ph <= ~m_ph;
      if (&dis) m_cnt <= 2'd0;
      else if (m_ph) m_cnt <= m_cnt + 2'd1;
      for (int b = 0; b < NB; b++) begin
        logic d, w;
        int t;
        d = ((b < NOUT) ? dis[b] : 1'b0) | ~pd_n;
        w = exp_wave(mode_a[b], m_ph, m_cnt);
        if (d) begin
          e_oe[b]   <= gate;
          e_true[b] <= gate ? ~stop : 1'b0;
          e_comp[b] <= gate ? stop : 1'b0;
          t = !pd_n ? 9 : (gate ? 8 : 7);
        end else begin
          e_oe[b] <= 1'b1; e_true[b] <= w; e_comp[b] <= ~w;
          t = mode_tag(mode_a[b]);
          if (b == NOUT && (&dis) && (mode_a[b] == 5'b10001 || mode_a[b] == 5'b10010)) t = 11;
        end
        if (tag_override != 0) t = tag_override;
        e_tag[b] <= t;
      end
    end
  end

  always @(negedge clk) begin
    if (check_on) begin
      for (int b = 0; b < NB; b++) begin
        checks++;
        if ({q_oe[b], q_true[b], q_comp[b]} !== {e_oe[b], e_true[b], e_comp[b]}) begin
          errors++;
          $display("FAIL %s bank %0d: actual oe/true/comp=%b%b%b expected %b%b%b",
                   tag_name(e_tag[b]), b, q_oe[b], q_true[b], q_comp[b],
                   e_oe[b], e_true[b], e_comp[b]);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all_modes(logic [4:0] m);
    for (int b = 0; b < NB; b++) mode_a[b] = m;
  endtask

  function automatic logic [4:0] pick_mode();
    case ($urandom % 5)
      0: return 5'b00000;
      1: return 5'b10000;
      2: return 5'b10001;
      3: return 5'b10010;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; dis = '0; gate = 1'b0; stop = 1'b0; pd_n = 1'b1;
    set_all_modes(5'b00000);
    step(4);
    // R12: reset state
    checks++;
    if (q_oe !== '0 || q_true !== '0 || q_comp !== '0) begin
      errors++;
      $display("FAIL R12 reset: actual oe=%b true=%b comp=%b expected all 0", q_oe, q_true, q_comp);
    end
    rst_n = 1'b1;
    check_on = 1;

    // R1..R5: each defined code plus an unlisted one
    mode_a[0] = 5'b00000; mode_a[1] = 5'b10000; mode_a[2] = 5'b10001;
    mode_a[3] = 5'b10010; mode_a[4] = 5'b01101; mode_a[5] = 5'b10011;
    step(20);

    // R6: enabled banks ignore gate and stop bits
    tag_override = 6;
    gate = 1'b1; stop = 1'b1; step(6);
    gate = 1'b0; stop = 1'b0; step(6);
    tag_override = 0;

    // R7 / R8: single-bank disable in both modes and levels
    dis = 5'b00101; gate = 1'b0; step(6);
    gate = 1'b1; stop = 1'b0; step(6);
    stop = 1'b1; step(6);
    dis = '0; step(4);

    // R9: power-down, both disable styles
    pd_n = 1'b0; gate = 1'b0; step(5);
    gate = 1'b1; stop = 1'b0; step(5);
    pd_n = 1'b1; step(4);

    // R11: feedback bank divided while all outputs off
    mode_a[NOUT] = 5'b10001; dis = '1; gate = 1'b0; step(12);
    mode_a[NOUT] = 5'b10010; step(12);

    // R10: restart phase after the all-off hold, on both phase alignments
    tag_override = 10;
    set_all_modes(5'b10010);
    dis = 5'b11110; step(16);
    dis = '1; step(7);
    dis = 5'b01111; step(16);
    dis = '1; step(6);
    dis = '0; step(16);
    tag_override = 0;

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom % 16 == 0) begin
        for (int b = 0; b < NB; b++) mode_a[b] = pick_mode();
      end
      if ($urandom % 4 == 0) begin
        case ($urandom % 4)
          0: dis = '1;
          1: dis = '0;
          default: dis = 5'($urandom);
        endcase
      end
      if ($urandom % 8 == 0) gate = 1'($urandom);
      if ($urandom % 8 == 0) stop = 1'($urandom);
      if ($urandom % 32 == 0) pd_n = ~pd_n;
    end
    pd_n = 1'b1; dis = '0;
    step(4);
    check_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule